// File: doc/BRIEF.md
# Paged Address Translation Unit

This block translates a 16-bit word address into a physical target for a small processor. The address space is split into 16 pages of 4096 words. Each page has a two-word descriptor in an internal table. Supervisor code writes the table through a narrow register port, and the same port reads back any descriptor word. For every access the unit takes the virtual address, the access kind and the current privilege mode. One clock later it reports one of two things. The first is a page fault with its cause. The second is a target, a page or device index and the word offset.

The descriptor picks one of four page types: on-chip memory, a blank page, an external device page or an on-chip ROM page. A blank page reads as zero and throws writes away with no fault, so it produces no memory request. Three protection bits per page can raise a fault: supervisor-only, write-protect and execute-protect. The unit records that a page has been written by setting a modified bit in its descriptor. Handling the fault and paging to slower storage are left to software.

Top module: `pgmmu_top`

## Requirements
- R1: After reset, word 0 of every descriptor is 0x0000 and word 1 of page p equals p. Every result output and cfg_denied are 0.
- R2: The page number is acc_addr[15:12]. A request with acc_valid high gives res_valid high on the next clock edge. A non-faulting result carries res_offset = acc_addr[11:0].
- R3: When cfg_we and cfg_super are both high, the next edge writes cfg_wdata into word cfg_word (0 or 1) of page cfg_sel. cfg_rdata always shows that word. The word 0 layout is: bit 15 supervisor-only, bit 14 write-protect, bit 13 execute-protect, bit 12 modified, bits 11:10 page type, bits 9:8 spare (stored only), bits 7:0 device number.
- R4: When cfg_we is high and cfg_super is low, the table does not change and cfg_denied is high for the following cycle.
- R5: A user-mode access (acc_super low) to a page with the supervisor-only bit set faults with res_cause = 1.
- R6: Access kind is encoded as 0 read, 1 write, 2 fetch, 3 treated as read. A fetch from an execute-protected page faults with cause 2. A write to a write-protected page faults with cause 3. When more than one check applies, the cause with the lowest number wins.
- R7: A faulting access gives res_fault = 1 and mem_req = 0. res_target, res_index, res_device and res_offset are zero, and the modified bit does not change.
- R8: Page type 0 (on-chip memory) gives res_target = 0, res_index = word1[3:0] zero-extended and mem_req = 1.
- R9: Page type 1 (blank) gives res_target = 1, res_index = 0 and mem_req = 0. A write to a blank page raises no fault and leaves the modified bit clear.
- R10: Page type 2 (device) gives res_target = 2, res_index = word 1, res_device = word0[7:0] and mem_req = 1. Page type 3 (ROM) gives res_target = 3, res_index = word 1, res_device = 0 and mem_req = 1.
- R11: A write that does not fault, to a page that is not blank, sets that page's modified bit at the same edge. If an accepted descriptor write hits the same page in the same cycle, the descriptor write wins.
- R12: With acc_valid low, the next cycle has res_valid = 0, res_fault = 0 and mem_req = 0, and no modified bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_super | input | 1 | Privilege of the descriptor writer (1 = supervisor) |
| cfg_sel | input | 4 | Page selected on the register port |
| cfg_word | input | 1 | Descriptor word selected (0 or 1) |
| cfg_wdata | input | 16 | Descriptor write data |
| cfg_rdata | output | 16 | Selected descriptor word |
| cfg_denied | output | 1 | Pulse: a user-mode descriptor write was refused |
| acc_valid | input | 1 | Translation request |
| acc_addr | input | 16 | Virtual word address |
| acc_kind | input | 2 | Access kind |
| acc_super | input | 1 | Current mode (1 = supervisor) |
| res_valid | output | 1 | Result valid |
| res_fault | output | 1 | Page fault |
| res_cause | output | 2 | Fault cause: 0 none, 1 supervisor-only, 2 execute, 3 write |
| res_target | output | 2 | Target: 0 on-chip, 1 blank, 2 device, 3 ROM |
| res_index | output | 16 | Physical page or device page index |
| res_device | output | 8 | External device number |
| res_offset | output | 12 | Word offset within the page |
| mem_req | output | 1 | A memory request is issued for this result |

## Verification
The hardest case to reach is a write access that marks a page modified in the same cycle that a supervisor descriptor write replaces the same page. Close behind it are pages that carry several protection bits at once, where only the priority decides the reported cause. The directed part of the stimulus lines up the access port and the register port on the same page in one cycle, and it programs a page with all three protection bits set. A long randomized phase then mixes descriptor writes from both privilege levels with accesses to a few pages, so these collisions recur under varied descriptor contents.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int WORD_W      = 16;
    localparam int LOCAL_IDX_W = 4;
    localparam int BIT_SUP     = 15;
    localparam int BIT_WP      = 14;
    localparam int BIT_XP      = 13;
    localparam int BIT_MOD     = 12;
    localparam int TYPE_LO     = 10;
    localparam int DEV_W       = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PT_LOCAL  = 2'd0,
        PT_BLANK  = 2'd1,
        PT_DEVICE = 2'd2,
        PT_ROM    = 2'd3
    } page_type_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SUPER = 2'd1,
        FLT_EXEC  = 2'd2,
        FLT_WRITE = 2'd3
    } fault_e;

    // Fields of a descriptor needed for a lookup
    typedef struct packed {
        logic             sup_only;
        logic             wr_prot;
        logic             ex_prot;
        page_type_e       ptype;
        logic [DEV_W-1:0] dev;
    } desc_view_t;

    // Protection checks in priority order
    function automatic fault_e fault_of(desc_view_t d, acc_kind_e k, logic sup);
        if (!sup && d.sup_only)            return FLT_SUPER;
        if (k == ACC_FETCH && d.ex_prot)   return FLT_EXEC;
        if (k == ACC_WRITE && d.wr_prot)   return FLT_WRITE;
        return FLT_NONE;
    endfunction
endpackage

// File: rtl/mmu_desc_table.sv
module mmu_desc_table
    import mmu_pkg::*;
#(
    parameter int NPAGES    = 16,
    parameter int PAGE_BITS = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic                               cfg_super,
    input  logic [PAGE_BITS-1:0]               cfg_sel,
    input  logic                               cfg_word,
    input  logic [WORD_W-1:0]                  cfg_wdata,
    output logic [WORD_W-1:0]                  cfg_rdata,
    output logic                               cfg_denied,
    input  logic [PAGE_BITS-1:0]               lk_page,
    output desc_view_t                         lk_view,
    output logic [WORD_W-1:0]                  lk_w1,
    input  logic                               mark_dirty,
    output logic [NPAGES-1:0][WORD_W-1:0]      w0_q
);
    logic [NPAGES-1:0][WORD_W-1:0] w1_q;
    logic                          cfg_ok;
    logic [WORD_W-1:0]             lk_w0;

    assign cfg_ok = cfg_we && cfg_super;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_denied <= 1'b0;
            for (int p = 0; p < NPAGES; p++) begin
                w0_q[p] <= '0;
                w1_q[p] <= WORD_W'(p);
            end
        end else begin
            cfg_denied <= cfg_we && !cfg_super;
            for (int p = 0; p < NPAGES; p++) begin
                if (cfg_ok && cfg_sel == PAGE_BITS'(p)) begin
                    if (cfg_word) w1_q[p] <= cfg_wdata;
                    else          w0_q[p] <= cfg_wdata;
                end else if (mark_dirty && lk_page == PAGE_BITS'(p)) begin
                    w0_q[p][BIT_MOD] <= 1'b1;
                end
            end
        end
    end

    assign cfg_rdata = cfg_word ? w1_q[cfg_sel] : w0_q[cfg_sel];

    assign lk_w0 = w0_q[lk_page];
    assign lk_w1 = w1_q[lk_page];

    always_comb begin
        lk_view.sup_only = lk_w0[BIT_SUP];
        lk_view.wr_prot  = lk_w0[BIT_WP];
        lk_view.ex_prot  = lk_w0[BIT_XP];
        lk_view.ptype    = page_type_e'(lk_w0[TYPE_LO+1:TYPE_LO]);
        lk_view.dev      = lk_w0[DEV_W-1:0];
    end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic              valid,
    input  desc_view_t        view,
    input  logic [WORD_W-1:0] w1,
    input  logic [1:0]        kind,
    input  logic              super_mode,
    output fault_e            cause,
    output page_type_e        ptype,
    output logic [WORD_W-1:0] index,
    output logic [DEV_W-1:0]  device,
    output logic              req,
    output logic              mark_dirty
);
    acc_kind_e k;

    assign k     = acc_kind_e'(kind);
    assign cause = fault_of(view, k, super_mode);
    assign ptype = view.ptype;

    always_comb begin
        index  = '0;
        device = '0;
        unique case (view.ptype)
            PT_LOCAL:  index = {{(WORD_W-LOCAL_IDX_W){1'b0}}, w1[LOCAL_IDX_W-1:0]};
            PT_BLANK:  index = '0;
            PT_DEVICE: begin
                index  = w1;
                device = view.dev;
            end
            PT_ROM:    index = w1;
        endcase
    end

    assign req        = valid && cause == FLT_NONE && view.ptype != PT_BLANK;
    assign mark_dirty = req && k == ACC_WRITE;
endmodule

// File: rtl/pgmmu_top.sv
module pgmmu_top
    import mmu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic                          cfg_super,
    input  logic [ADDR_W-OFF_W-1:0]       cfg_sel,
    input  logic                          cfg_word,
    input  logic [15:0]                   cfg_wdata,
    output logic [15:0]                   cfg_rdata,
    output logic                          cfg_denied,
    input  logic                          acc_valid,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [1:0]                    acc_kind,
    input  logic                          acc_super,
    output logic                          res_valid,
    output logic                          res_fault,
    output logic [1:0]                    res_cause,
    output logic [1:0]                    res_target,
    output logic [15:0]                   res_index,
    output logic [7:0]                    res_device,
    output logic [OFF_W-1:0]              res_offset,
    output logic                          mem_req
);
    localparam int PAGE_BITS = ADDR_W - OFF_W;
    localparam int NPAGES    = 1 << PAGE_BITS;

    logic [PAGE_BITS-1:0]          page;
    desc_view_t                    view;
    logic [WORD_W-1:0]             w1;
    fault_e                        cause;
    page_type_e                    ptype;
    logic [WORD_W-1:0]             index;
    logic [DEV_W-1:0]              device;
    logic                          req;
    logic                          dirty;
    logic [NPAGES-1:0][WORD_W-1:0] tbl_w0;
    logic                          ok;

    assign page = acc_addr[ADDR_W-1:OFF_W];

    mmu_desc_table #(.NPAGES(NPAGES), .PAGE_BITS(PAGE_BITS)) u_table (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_super  (cfg_super),
        .cfg_sel    (cfg_sel),
        .cfg_word   (cfg_word),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_denied (cfg_denied),
        .lk_page    (page),
        .lk_view    (view),
        .lk_w1      (w1),
        .mark_dirty (dirty),
        .w0_q       (tbl_w0)
    );

    mmu_xlate u_xlate (
        .valid      (acc_valid),
        .view       (view),
        .w1         (w1),
        .kind       (acc_kind),
        .super_mode (acc_super),
        .cause      (cause),
        .ptype      (ptype),
        .index      (index),
        .device     (device),
        .req        (req),
        .mark_dirty (dirty)
    );

    assign ok = acc_valid && cause == FLT_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_fault  <= 1'b0;
            res_cause  <= FLT_NONE;
            res_target <= '0;
            res_index  <= '0;
            res_device <= '0;
            res_offset <= '0;
            mem_req    <= 1'b0;
        end else begin
            res_valid  <= acc_valid;
            res_fault  <= acc_valid && cause != FLT_NONE;
            res_cause  <= acc_valid ? cause : FLT_NONE;
            res_target <= ok ? ptype : PT_LOCAL;
            res_index  <= ok ? index : '0;
            res_device <= ok ? device : '0;
            res_offset <= ok ? acc_addr[OFF_W-1:0] : '0;
            mem_req    <= req;
        end
    end
endmodule

// File: rtl/mmu_sva.sv
module mmu_sva #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   cfg_we,
    input logic                                   cfg_super,
    input logic                                   cfg_denied,
    input logic                                   acc_valid,
    input logic [ADDR_W-1:0]                      acc_addr,
    input logic [1:0]                             acc_kind,
    input logic                                   acc_super,
    input logic                                   res_valid,
    input logic                                   res_fault,
    input logic [1:0]                             res_cause,
    input logic [1:0]                             res_target,
    input logic                                   mem_req,
    input logic [(1<<(ADDR_W-OFF_W))-1:0][15:0]   tbl_w0
);
    logic [15:0] cur;
    assign cur = tbl_w0[acc_addr[ADDR_W-1:OFF_W]];

    assert_user_cfg_denied_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_super) |=> cfg_denied);

    assert_super_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_super && cur[15]) |=> (res_fault && res_cause == 2'd1));

    assert_exec_fault_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == 2'd2 && cur[13] && (acc_super || !cur[15]))
        |=> (res_fault && res_cause == 2'd2));

    assert_fault_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        res_fault |-> !mem_req);

    assert_blank_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault && res_target == 2'd1) |-> !mem_req);

    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!res_valid && !res_fault && !mem_req));
endmodule

bind pgmmu_top mmu_sva #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_super  (cfg_super),
    .cfg_denied (cfg_denied),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_kind   (acc_kind),
    .acc_super  (acc_super),
    .res_valid  (res_valid),
    .res_fault  (res_fault),
    .res_cause  (res_cause),
    .res_target (res_target),
    .mem_req    (mem_req),
    .tbl_w0     (tbl_w0)
);

// File: tb/tb_pgmmu_top.sv
`timescale 1ns/1ps
module tb_pgmmu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_super, cfg_word;
    logic [3:0]  cfg_sel;
    logic [15:0] cfg_wdata, cfg_rdata;
    logic        cfg_denied;
    logic        acc_valid, acc_super;
    logic [15:0] acc_addr;
    logic [1:0]  acc_kind;
    logic        res_valid, res_fault, mem_req;
    logic [1:0]  res_cause, res_target;
    logic [15:0] res_index;
    logic [7:0]  res_device;
    logic [11:0] res_offset;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_w0 [16];
    logic [15:0] m_w1 [16];

    always #10 clk = ~clk;

    pgmmu_top dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_super(cfg_super), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_denied(cfg_denied),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_super(acc_super),
        .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause),
        .res_target(res_target), .res_index(res_index), .res_device(res_device),
        .res_offset(res_offset), .mem_req(mem_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at a negedge, predict, then compare at the next negedge
    task automatic step(input string tag,
                        input logic av, input logic [15:0] addr, input logic [1:0] kind,
                        input logic sup,
                        input logic cw, input logic cs, input logic [3:0] csel,
                        input logic cword, input logic [15:0] cdata);
        int pg, cause, typ, e_tgt, e_idx, e_dev, e_off;
        logic [15:0] d;
        logic e_req, e_dirty, cfg_hit;
        acc_valid = av; acc_addr = addr; acc_kind = kind; acc_super = sup;
        cfg_we = cw; cfg_super = cs; cfg_sel = csel; cfg_word = cword; cfg_wdata = cdata;
        pg = int'(addr[15:12]);
        d = m_w0[pg];
        typ = int'(d[11:10]);
        if (!sup && d[15])              cause = 1;
        else if (kind == 2'd2 && d[13]) cause = 2;
        else if (kind == 2'd1 && d[14]) cause = 3;
        else                            cause = 0;
        if (!av) cause = 0;
        e_tgt = 0; e_idx = 0; e_dev = 0; e_off = 0; e_req = 1'b0;
        if (av && cause == 0) begin
            e_tgt = typ;
            e_off = int'(addr[11:0]);
            e_req = (typ != 1);
            if (typ == 0) e_idx = int'(m_w1[pg][3:0]);
            else if (typ >= 2) e_idx = int'(m_w1[pg]);
            if (typ == 2) e_dev = int'(d[7:0]);
        end
        e_dirty = e_req && kind == 2'd1;
        cfg_hit = cw && cs;
        if (e_dirty && !(cfg_hit && int'(csel) == pg)) m_w0[pg][12] = 1'b1;
        if (cfg_hit) begin
            if (cword) m_w1[csel] = cdata; else m_w0[csel] = cdata;
        end
        @(negedge clk);
        chk({tag, "/R12"}, "res_valid", int'(res_valid), int'(av));
        chk({tag, "/R5"},  "res_fault", int'(res_fault), int'(cause != 0));
        chk({tag, "/R6"},  "res_cause", int'(res_cause), cause);
        chk({tag, "/R8"},  "res_target", int'(res_target), e_tgt);
        chk({tag, "/R8"},  "res_index", int'(res_index), e_idx);
        chk({tag, "/R10"}, "res_device", int'(res_device), e_dev);
        chk({tag, "/R2"},  "res_offset", int'(res_offset), e_off);
        chk({tag, "/R7"},  "mem_req", int'(mem_req), int'(e_req));
        chk({tag, "/R4"},  "cfg_denied", int'(cfg_denied), int'(cw && !cs));
        chk({tag, "/R3"},  "cfg_rdata", int'(cfg_rdata),
            int'(cword ? m_w1[csel] : m_w0[csel]));
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 16'h0, 2'd0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 16'h0);
    endtask

    task automatic wr(input string tag, input logic [3:0] p, input logic w, input logic [15:0] v);
        step(tag, 1'b0, 16'h0, 2'd0, 1'b1, 1'b1, 1'b1, p, w, v);
    endtask

    task automatic acc(input string tag, input logic [15:0] a, input logic [1:0] k, input logic s);
        step(tag, 1'b1, a, k, s, 1'b0, 1'b1, a[15:12], 1'b0, 16'h0);
    endtask

    task automatic peek(input string tag, input logic [3:0] p, input logic w, input logic [15:0] exp);
        step(tag, 1'b0, 16'h0, 2'd0, 1'b1, 1'b0, 1'b1, p, w, 16'h0);
        chk(tag, "readback", int'(cfg_rdata), int'(exp));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < 16; p++) begin
            m_w0[p] = 16'h0;
            m_w1[p] = 16'(p);
        end
        rst = 1'b1;
        acc_valid = 0; acc_addr = 0; acc_kind = 0; acc_super = 0;
        cfg_we = 0; cfg_super = 0; cfg_sel = 0; cfg_word = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "mem_req", int'(mem_req), 0);
        chk("R1", "cfg_denied", int'(cfg_denied), 0);
        rst = 1'b0;
        for (int p = 0; p < 16; p++) begin
            peek("R1", 4'(p), 1'b0, 16'h0);
            peek("R1", 4'(p), 1'b1, 16'(p));
        end

        // Program pages
        wr("R3", 4'd1, 1'b0, 16'h0400);          // blank
        wr("R3", 4'd2, 1'b0, 16'h085A);          // device 0x5A
        wr("R3", 4'd2, 1'b1, 16'h1234);
        wr("R3", 4'd3, 1'b0, 16'h0C00);          // ROM
        wr("R3", 4'd3, 1'b1, 16'h0077);
        wr("R3", 4'd4, 1'b0, 16'h8000);          // supervisor only
        wr("R3", 4'd5, 1'b0, 16'h4000);          // write protect
        wr("R3", 4'd6, 1'b0, 16'h2000);          // execute protect
        wr("R3", 4'd7, 1'b0, 16'hE300);          // all protections, spare bits
        wr("R3", 4'd8, 1'b1, 16'hABC9);          // local, index 9
        peek("R3", 4'd7, 1'b0, 16'hE300);

        acc("R2", 16'h0123, 2'd0, 1'b0);
        acc("R8", 16'h8FFF, 2'd0, 1'b0);
        acc("R9", 16'h1456, 2'd0, 1'b0);
        acc("R9", 16'h1457, 2'd1, 1'b0);
        peek("R9", 4'd1, 1'b0, 16'h0400);
        acc("R10", 16'h2001, 2'd0, 1'b0);
        acc("R10", 16'h3002, 2'd2, 1'b1);
        acc("R5", 16'h4003, 2'd0, 1'b0);
        acc("R5", 16'h4004, 2'd0, 1'b1);
        acc("R6", 16'h5005, 2'd1, 1'b0);
        acc("R6", 16'h5006, 2'd2, 1'b0);
        acc("R6", 16'h6007, 2'd2, 1'b0);
        acc("R6", 16'h6008, 2'd1, 1'b0);
        acc("R6", 16'h6009, 2'd3, 1'b0);
        acc("R6", 16'h700A, 2'd1, 1'b0);
        acc("R6", 16'h700B, 2'd2, 1'b1);
        acc("R6", 16'h700C, 2'd1, 1'b1);
        peek("R7", 4'd7, 1'b0, 16'hE300);
        peek("R7", 4'd5, 1'b0, 16'h4000);
        acc("R11", 16'h8010, 2'd1, 1'b0);
        peek("R11", 4'd8, 1'b0, 16'h1000);
        acc("R11", 16'h2011, 2'd1, 1'b1);
        peek("R11", 4'd2, 1'b0, 16'h185A);
        // R11 collision: descriptor write wins on the same page
        step("R11", 1'b1, 16'h3012, 2'd1, 1'b1, 1'b1, 1'b1, 4'd3, 1'b1, 16'h0055);
        peek("R11", 4'd3, 1'b0, 16'h0C00);
        peek("R11", 4'd3, 1'b1, 16'h0055);
        // R4: user write refused
        step("R4", 1'b0, 16'h0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd9, 1'b0, 16'hFFFF);
        peek("R4", 4'd9, 1'b0, 16'h0000);
        idle("R12");
        step("R12", 1'b0, 16'h9000, 2'd1, 1'b1, 1'b0, 1'b1, 4'd9, 1'b0, 16'h0);
        peek("R12", 4'd9, 1'b0, 16'h0000);

        // Randomized mix on pages 0..7
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a, v;
            logic [3:0] cp;
            a = 16'($urandom);
            a[15] = 1'b0;
            v = 16'($urandom);
            cp = 4'($urandom_range(0, 7));
            step("RND", 1'($urandom_range(0, 3) != 0), a, 2'($urandom),
                 1'($urandom), 1'($urandom_range(0, 4) == 0), 1'($urandom),
                 cp, 1'($urandom), v);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule